// File: doc/BRIEF.md
# Bus-Injection Program Memory Loader

This block fills an SRAM that stands in for a target computer's program ROM. It has no path to the SRAM address lines. The target's own program counter drives those lines at all times. To steer the program counter, the loader drives the target clock and places opcodes on the shared instruction/data bus. The target then executes these opcodes, and its PC walks through the program space one address at a time.

A load starts with a one-cycle `start_i` pulse, with the image length on `len_i`. The loader first brings the PC to address zero. Each byte from the host (valid/ready) is then written into the SRAM with an active-low write strobe, and a no-op clock pulse advances the PC. After the last byte, the loader brings the PC back to zero. It then releases the bus, enables the SRAM outputs and lets the target clock run free. A new `start_i` in run mode begins another load.

Top module: `bus_inject_loader`

## Requirements
- R1: After reset the outputs are idle: target clock low, `sram_we_n_o` high, `sram_oe_n_o` high, bus not driven, `done_o` low and `byte_ready_o` low.
- R2: The PC-return sequence injects three opcodes, each with one target clock pulse: load-Y-with-zero (default 8'h14), then jump-to-Y:00 (default 8'hE0), then no-op (default 8'h02). It runs once when a load starts and once after the final byte, so the target PC is 0 when run mode begins.
- R3: For each host byte, the byte is driven on the bus and `sram_we_n_o` pulses low while no clock pulse occurs. The bus then carries the no-op opcode while the target clock pulses once, which advances the PC by one. Byte k therefore lands at address k.
- R4: The write strobe and the target clock pulse are never active together. The bus value is unchanged in the cycle before each strobe or clock edge and in the cycle of that edge, for every edge taken while the bus is driven.
- R5: In run mode the bus is released, `sram_oe_n_o` is low, `sram_we_n_o` is high, `done_o` is high and the target clock toggles every system cycle.
- R6: `bus_drive_o` high and `sram_oe_n_o` low never occur in the same cycle.
- R7: When `done_o` is high, `byte_count_o` equals the length latched at start. A length of 0 writes nothing and runs the PC-return sequence twice.
- R8: `byte_ready_o` is high only while the loader waits for a byte. A `start_i` that arrives while a load is in progress is ignored, and that load completes unchanged.
- R9: `start_i` in run mode stops the free-running clock and begins a new load. A new load starts from idle as well.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a load (accepted in idle or run mode) |
| len_i | input | CNT_W (17) | Number of bytes to load, 0 to MAX_LEN |
| byte_i | input | DATA_W (8) | Host byte |
| byte_valid_i | input | 1 | Host byte valid |
| byte_ready_o | output | 1 | Loader accepts a byte this cycle |
| tgt_clk_o | output | 1 | Target clock |
| sram_we_n_o | output | 1 | SRAM write enable, active low |
| sram_oe_n_o | output | 1 | SRAM output enable, active low |
| bus_drive_o | output | 1 | Loader drives the instruction/data bus |
| bus_data_o | output | DATA_W (8) | Value for the instruction/data bus |
| done_o | output | 1 | Run mode reached |
| byte_count_o | output | CNT_W (17) | Bytes written in the current load |

## Verification
The assertions assume the host holds `len_i` steady only while `start_i` is sampled, and that `start_i` is a single-cycle pulse. They place no constraint on how `byte_valid_i` and `byte_i` behave around the handshake. The stimulus issues `start_i` only from idle or run mode, except for one deliberate pulse in the middle of a load. Host bytes arrive with random gaps, and the length never exceeds `MAX_LEN`. A behavioural model of the target's PC, including the jump delay slot, and of the SRAM follows the clock and write strobe edges. This model lets the bench compare the image and the final PC against the values it expects.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef enum logic [2:0] {
    LD_IDLE,
    LD_PARK,
    LD_RSEQ,
    LD_WAIT,
    LD_WRITE,
    LD_STEP,
    LD_RUN
  } ld_state_e;
endpackage

// File: rtl/ldr_phase_timer.sv
// Splits one bus step into setup, strobe-active and hold cycles.
module ldr_phase_timer #(
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic active,
  output logic last
);
  localparam int TOTAL = SETUP_CYC + PULSE_CYC + HOLD_CYC;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam logic [CW-1:0] ON_AT  = CW'(SETUP_CYC);
  localparam logic [CW-1:0] OFF_AT = CW'(SETUP_CYC + PULSE_CYC);
  localparam logic [CW-1:0] END_AT = CW'(TOTAL - 1);

  logic [CW-1:0] cnt;

  assign last   = en && (cnt == END_AT);
  assign active = en && (cnt >= ON_AT) && (cnt < OFF_AT);

  always_ff @(posedge clk) begin
    if (rst || !en || last) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ldr_byte_counter.sv
// Counts bytes written during the current load.
module ldr_byte_counter #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clr) count <= '0;
    else if (inc)   count <= count + 1'b1;
  end
endmodule

// File: rtl/bus_inject_loader.sv
module bus_inject_loader #(
  parameter int DATA_W    = 8,
  parameter int MAX_LEN   = 65536,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 2,
  parameter int HOLD_CYC  = 1,
  parameter logic [DATA_W-1:0] OPC_LDY0 = 8'h14,
  parameter logic [DATA_W-1:0] OPC_JMPY = 8'hE0,
  parameter logic [DATA_W-1:0] OPC_NOP  = 8'h02,
  localparam int CNT_W = $clog2(MAX_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  len_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              tgt_clk_o,
  output logic              sram_we_n_o,
  output logic              sram_oe_n_o,
  output logic              bus_drive_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  byte_count_o
);
  import loader_pkg::*;

  ld_state_e         state;
  logic [1:0]        rs_idx;
  logic              rs_final;
  logic [CNT_W-1:0]  len_q;
  logic [DATA_W-1:0] byte_q;
  logic [CNT_W-1:0]  byte_cnt;
  logic              ph_en, ph_act, ph_last;
  logic              cnt_clr, cnt_inc, last_byte;
  logic              drv_c, we_c, clk_c;
  logic [DATA_W-1:0] data_c;

  assign ph_en     = (state == LD_RSEQ) || (state == LD_WRITE) || (state == LD_STEP);
  assign cnt_clr   = (state == LD_PARK);
  assign cnt_inc   = (state == LD_STEP) && ph_last;
  assign last_byte = ((byte_cnt + 1'b1) == len_q);

  ldr_phase_timer #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_timer (
    .clk(clk), .rst(rst), .en(ph_en), .active(ph_act), .last(ph_last)
  );

  ldr_byte_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc), .count(byte_cnt)
  );

  // Sequencer
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= LD_IDLE;
      rs_idx   <= '0;
      rs_final <= 1'b0;
      len_q    <= '0;
      byte_q   <= '0;
    end else begin
      case (state)
        LD_IDLE, LD_RUN: begin
          if (start_i) begin
            state <= LD_PARK;
            len_q <= len_i;
          end
        end
        LD_PARK: begin
          state    <= LD_RSEQ;
          rs_idx   <= '0;
          rs_final <= 1'b0;
        end
        LD_RSEQ: begin
          if (ph_last) begin
            if (rs_idx != 2'd2) begin
              rs_idx <= rs_idx + 1'b1;
            end else if (rs_final) begin
              state <= LD_RUN;
            end else if (byte_cnt == len_q) begin
              rs_idx   <= '0;
              rs_final <= 1'b1;
            end else begin
              state <= LD_WAIT;
            end
          end
        end
        LD_WAIT: begin
          if (byte_valid_i) begin
            byte_q <= byte_i;
            state  <= LD_WRITE;
          end
        end
        LD_WRITE: if (ph_last) state <= LD_STEP;
        LD_STEP: begin
          if (ph_last) begin
            if (last_byte) begin
              state    <= LD_RSEQ;
              rs_idx   <= '0;
              rs_final <= 1'b1;
            end else begin
              state <= LD_WAIT;
            end
          end
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  // Bus and strobe values for the current step
  always_comb begin
    drv_c  = (state == LD_RSEQ) || (state == LD_WAIT) ||
             (state == LD_WRITE) || (state == LD_STEP);
    we_c   = (state == LD_WRITE) && ph_act;
    clk_c  = ((state == LD_RSEQ) || (state == LD_STEP)) && ph_act;
    data_c = '0;
    if (state == LD_RSEQ) begin
      case (rs_idx)
        2'd0:    data_c = OPC_LDY0;
        2'd1:    data_c = OPC_JMPY;
        default: data_c = OPC_NOP;
      endcase
    end else if (state == LD_WRITE) begin
      data_c = byte_q;
    end else if (drv_c) begin
      data_c = OPC_NOP;
    end
  end

  // Registered pin outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_clk_o   <= 1'b0;
      sram_we_n_o <= 1'b1;
      sram_oe_n_o <= 1'b1;
      bus_drive_o <= 1'b0;
      bus_data_o  <= '0;
      done_o      <= 1'b0;
    end else begin
      tgt_clk_o   <= (state == LD_RUN) ? ~tgt_clk_o : clk_c;
      sram_we_n_o <= ~we_c;
      sram_oe_n_o <= (state != LD_RUN);
      bus_drive_o <= drv_c;
      bus_data_o  <= data_c;
      done_o      <= (state == LD_RUN);
    end
  end

  assign byte_ready_o = (state == LD_WAIT);
  assign byte_count_o = byte_cnt;
endmodule

// File: rtl/bus_inject_loader_chk.sv
module bus_inject_loader_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              tgt_clk_o,
  input logic              sram_we_n_o,
  input logic              sram_oe_n_o,
  input logic              bus_drive_o,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              done_o,
  input logic              byte_ready_o
);
  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(!sram_we_n_o && tgt_clk_o));

  p_we_setup_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n_o) |-> $past(bus_drive_o) && $stable(bus_data_o));

  p_we_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n_o) |-> bus_drive_o && $stable(bus_data_o));

  p_clk_setup_r4: assert property (@(posedge clk) disable iff (rst)
    ($rose(tgt_clk_o) && bus_drive_o) |-> $past(bus_drive_o) && $stable(bus_data_o));

  p_clk_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ($fell(tgt_clk_o) && $past(bus_drive_o)) |-> $stable(bus_data_o));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (rst)
    !(bus_drive_o && !sram_oe_n_o));

  p_run_pins_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !bus_drive_o && !sram_oe_n_o && sram_we_n_o);

  p_run_toggle_r5: assert property (@(posedge clk) disable iff (rst)
    (done_o && $past(done_o)) |-> (tgt_clk_o != $past(tgt_clk_o)));

  p_ready_idle_r8: assert property (@(posedge clk) disable iff (rst)
    byte_ready_o |-> !done_o && bus_drive_o);
endmodule

bind bus_inject_loader bus_inject_loader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .tgt_clk_o(tgt_clk_o), .sram_we_n_o(sram_we_n_o),
  .sram_oe_n_o(sram_oe_n_o), .bus_drive_o(bus_drive_o), .bus_data_o(bus_data_o),
  .done_o(done_o), .byte_ready_o(byte_ready_o)
);

// File: tb/test_bus_inject_loader.sv
module test_bus_inject_loader;
  localparam int CNT_W = 17;
  localparam logic [7:0] LDY = 8'h14, JMP = 8'hE0, NOP = 8'h02;

  logic clk = 0, rst = 1;
  logic start_i = 0, byte_valid_i = 0;
  logic [CNT_W-1:0] len_i = '0;
  logic [7:0] byte_i = '0;
  logic byte_ready_o, tgt_clk_o, sram_we_n_o, sram_oe_n_o, bus_drive_o, done_o;
  logic [7:0] bus_data_o;
  logic [CNT_W-1:0] byte_count_o;

  int checks = 0, errors = 0, cyc = 0;

  bus_inject_loader i_bus_inject_loader (
    .clk(clk), .rst(rst), .start_i(start_i), .len_i(len_i), .byte_i(byte_i),
    .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o), .tgt_clk_o(tgt_clk_o),
    .sram_we_n_o(sram_we_n_o), .sram_oe_n_o(sram_oe_n_o), .bus_drive_o(bus_drive_o),
    .bus_data_o(bus_data_o), .done_o(done_o), .byte_count_o(byte_count_o)
  );

  always #10 clk = ~clk;

  // Target and SRAM model
  logic [15:0] pc = 16'h1234;
  logic [7:0]  y_reg = 8'h5A;
  logic        pend = 0;
  logic [15:0] pend_tgt = '0;
  logic [7:0]  mem [int];
  logic [7:0]  hist0 = 0, hist1 = 0, hist2 = 0;
  logic p_clk = 0, p_we = 1, p_drv = 0;
  logic [7:0] p_data = 0;
  int r4_viol = 0, r6_viol = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (tgt_clk_o && !sram_we_n_o) r4_viol++;
      if (bus_drive_o && !sram_oe_n_o) r6_viol++;
      if (sram_we_n_o != p_we && bus_data_o != p_data) r4_viol++;
      if (tgt_clk_o != p_clk && p_drv && bus_data_o != p_data) r4_viol++;
      if (!sram_we_n_o && p_we) mem[int'(pc)] = bus_data_o;
      if (tgt_clk_o && !p_clk) begin
        logic [7:0] op;
        op = bus_drive_o ? bus_data_o : NOP;
        if (bus_drive_o) begin hist0 = hist1; hist1 = hist2; hist2 = op; end
        pc = pend ? pend_tgt : pc + 16'd1;
        pend = 0;
        if (op == JMP) begin pend = 1; pend_tgt = {y_reg, 8'h00}; end
        if (op == LDY) y_reg = 8'h00;
      end
    end
    p_clk = tgt_clk_o; p_we = sram_we_n_o; p_drv = bus_drive_o; p_data = bus_data_o;
  end

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 190000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      report();
    end
  end

  task automatic chk(input string req, input bit ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_load(input int n, input bit poke_start);
    logic [7:0] exp [];
    int gap, waited, bad;
    bit run_ok;
    exp = new[n];
    foreach (exp[i]) exp[i] = 8'($urandom);
    mem.delete();
    r4_viol = 0; r6_viol = 0;
    @(negedge clk); start_i = 1; len_i = CNT_W'(n);
    @(negedge clk); start_i = 0;
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      gap = $urandom_range(0, 3);
      repeat (gap) @(negedge clk);
      byte_valid_i = 1; byte_i = exp[i];
      if (poke_start && i == 1) begin start_i = 1; len_i = 5; end
      waited = 0;
      while (!byte_ready_o && waited < 100) begin @(negedge clk); waited++; end
      @(negedge clk);
      byte_valid_i = 0; start_i = 0; byte_i = 8'($urandom);
    end
    waited = 0;
    while (!done_o && waited < 2000) begin @(negedge clk); waited++; end
    chk("R5 done reached", done_o, done_o, 1);
    chk("R2 pc at zero", pc == 16'h0000, pc, 0);
    chk("R2 return opcodes", {hist0, hist1, hist2} == {LDY, JMP, NOP}, {hist0, hist1, hist2}, {LDY, JMP, NOP});
    chk("R7 byte count", byte_count_o == CNT_W'(n), byte_count_o, n);
    bad = 0;
    for (int i = 0; i < n; i++)
      if (!mem.exists(i) || mem[i] != exp[i]) bad++;
    chk(poke_start ? "R8 image intact after stray start" : "R3 image", bad == 0, bad, 0);
    chk("R3 no writes beyond image", mem.size() == n, mem.size(), n);
    chk("R4 strobe spacing", r4_viol == 0, r4_viol, 0);
    chk("R6 contention", r6_viol == 0, r6_viol, 0);
    run_ok = 1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (tgt_clk_o == p_clk) run_ok = 0;
      if (bus_drive_o || sram_oe_n_o || !sram_we_n_o || byte_ready_o || !done_o) run_ok = 0;
    end
    chk("R5 run mode pins", run_ok, run_ok, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset pins", !tgt_clk_o && sram_we_n_o && sram_oe_n_o && !bus_drive_o,
        {tgt_clk_o, sram_we_n_o, sram_oe_n_o, bus_drive_o}, 4'b0110);
    chk("R1 reset flags", !done_o && !byte_ready_o, {done_o, byte_ready_o}, 0);
    chk("R7 count at reset", byte_count_o == 0, byte_count_o, 0);
    void'($urandom(32'd1234));
    do_load(5, 0);          // directed, from idle (R9)
    do_load(0, 0);          // empty image (R7), restart from run (R9)
    do_load(1, 0);          // single byte
    do_load(12, 1);         // stray start mid-load (R8)
    repeat (37) @(negedge clk);
    do_load(300, 0);        // long random image after free running (R9)
    report();
  end
endmodule